// File: doc/BRIEF.md
# Binary Strip Hit Pipeline with Sparse Trigger Readout

This block is the digital back end of a many-channel binary strip readout chip. On every bunch clock it takes one comparator bit per channel and turns it into a hit bit. A mode input chooses between two detection rules. In edge sensing, a hit is a rising transition of the comparator bit. In level sensing, a hit is any cycle in which the comparator bit is high. The hit slices then pass through a fixed-latency store. This gives the trigger decision time to arrive before the data for a crossing is needed.

A trigger pulse takes the slice that was sampled exactly the latency depth earlier and copies it into a readout buffer. The buffer is then drained with zero suppression. Each channel that fired gives one address word, in ascending channel order, one per clock. A closing marker ends the event. A trigger that arrives while an event is still being drained is discarded, and it sets a sticky error flag.

Top module: `strip_hit_pipe`

## Requirements
- R1: With `sense_level`=1, a channel's hit bit equals its comparator bit in every cycle, so a comparator held high for several cycles produces a hit in each of them.
- R2: With `sense_level`=0, a hit is recorded only in a cycle where the comparator bit is 1 and was 0 in the previous cycle; a comparator held high produces no hit in its second and later cycles.
- R3: A trigger sampled at clock edge T reads out the hit slice recorded at edge T-DEPTH (DEPTH=132 by default); the slices recorded one edge earlier or later are not read out by that trigger.
- R4: Readout is zero suppressed: only channels whose hit bit is 1 in the latched slice produce a word, `hit_valid`=1 with `hit_addr` equal to the channel index (7 bits for 128 channels), one word per cycle, in strictly ascending order, the first in the cycle right after the trigger edge.
- R5: `eoe` is high for exactly one cycle, in the cycle right after the last address word; an event with no hits produces only `eoe`, in the first cycle after the trigger edge.
- R6: A trigger sampled while a readout is in progress (from the cycle after the accepted trigger edge up to and including the `eoe` cycle) is dropped and sets `ovf_err`, which stays 1 until reset.
- R7: Reset clears `ovf_err` and the readout state, and makes the store read as empty until it has been refilled. In edge mode, a comparator that is already high in the first cycle after reset gives no hit.
- R8: `hit_valid` and `eoe` are never high together, and the cycle after `eoe` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_level | input | 1 | 1 = level sensing, 0 = edge sensing |
| comp | input | NCH | One comparator bit per channel |
| trig | input | 1 | Trigger pulse, sampled on the rising edge |
| hit_valid | output | 1 | An address word is present |
| hit_addr | output | $clog2(NCH) | Channel index of the present word |
| eoe | output | 1 | End-of-event marker |
| ovf_err | output | 1 | Sticky flag for a dropped trigger |

## Verification
A comparator pattern driven before edge E is due at the readout only if the trigger is sampled at edge E+132. Its first address is due in the cycle after that edge, and every further address and the closing marker follow on consecutive cycles. The bench counts clock edges and schedules every trigger against that count. It then samples each output on the falling edge of the cycle in which the output is due, and it also samples the idle cycle that follows. Triggers placed one edge early and one edge late confirm that neighbouring slices stay hidden. The overflow flag is checked on the cycle after the second trigger, and checked again after a long idle stretch.

// File: rtl/strip_pkg.sv
package strip_pkg;
   localparam int unsigned NCH_DEF   = 128;
   localparam int unsigned DEPTH_DEF = 132;

   typedef enum logic {
      SENSE_EDGE  = 1'b0,
      SENSE_LEVEL = 1'b1
   } sense_e;
endpackage

// File: rtl/strip_hit_detect.sv
module strip_hit_detect
   import strip_pkg::*;
#(
   parameter int unsigned NCH = NCH_DEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  sense_e         mode,
   input  logic [NCH-1:0] comp,
   output logic [NCH-1:0] hit
);
   logic [NCH-1:0] prev_q;

   // History resets to ones: a bit already high after reset is not an edge.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= comp;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign hit[c] = (mode == SENSE_LEVEL) ? comp[c] : (comp[c] & ~prev_q[c]);
   end
endmodule

// File: rtl/strip_latency_pipe.sv
module strip_latency_pipe #(
   parameter int unsigned NCH   = strip_pkg::NCH_DEF,
   parameter int unsigned DEPTH = strip_pkg::DEPTH_DEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] din,
   output logic [NCH-1:0] dout
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [NCH-1:0] mem [DEPTH];
   logic [PW-1:0]  wptr_q;
   logic           full_q;

   always_ff @(posedge clk) begin
      mem[wptr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         full_q <= 1'b0;
      end else begin
         wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
         if (wptr_q == LAST) full_q <= 1'b1;
      end
   end

   // Oldest entry; reads as empty until one full lap since reset.
   assign dout = full_q ? mem[wptr_q] : '0;
endmodule

// File: rtl/strip_sparse_readout.sv
module strip_sparse_readout #(
   parameter int unsigned NCH = strip_pkg::NCH_DEF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   trig,
   input  logic [NCH-1:0]         slice,
   output logic                   busy,
   output logic                   hit_valid,
   output logic [$clog2(NCH)-1:0] hit_addr,
   output logic                   eoe,
   output logic                   ovf_err
);
   localparam int unsigned AW = $clog2(NCH);
   localparam logic [NCH-1:0] ONE = NCH'(1);

   logic [NCH-1:0] buf_q;
   logic           busy_q;
   logic           ovf_q;
   logic [AW-1:0]  low;
   logic           any;

   always_comb begin
      low = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (buf_q[i]) low = AW'(i);
      end
   end

   assign any = |buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         busy_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (trig && busy_q) ovf_q <= 1'b1;
         if (trig && !busy_q) begin
            buf_q  <= slice;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (any) buf_q  <= buf_q & ~(ONE << low);
            else     busy_q <= 1'b0;
         end
      end
   end

   assign busy      = busy_q;
   assign hit_valid = busy_q & any;
   assign eoe       = busy_q & ~any;
   assign hit_addr  = low;
   assign ovf_err   = ovf_q;
endmodule

// File: rtl/strip_hit_pipe.sv
module strip_hit_pipe
   import strip_pkg::*;
#(
   parameter int unsigned NCH   = NCH_DEF,
   parameter int unsigned DEPTH = DEPTH_DEF,
   localparam int unsigned AW   = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sense_level,
   input  logic [NCH-1:0] comp,
   input  logic           trig,
   output logic           hit_valid,
   output logic [AW-1:0]  hit_addr,
   output logic           eoe,
   output logic           ovf_err
);
   if (NCH < 2) begin : g_bad_nch
      $error("strip_hit_pipe: NCH must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("strip_hit_pipe: DEPTH must be at least 2");
   end

   logic [NCH-1:0] hit;
   logic [NCH-1:0] old_slice;
   logic           rd_busy;

   strip_hit_detect #(.NCH(NCH)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (sense_e'(sense_level)),
      .comp  (comp),
      .hit   (hit)
   );

   strip_latency_pipe #(.NCH(NCH), .DEPTH(DEPTH)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (hit),
      .dout  (old_slice)
   );

   strip_sparse_readout #(.NCH(NCH)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .slice     (old_slice),
      .busy      (rd_busy),
      .hit_valid (hit_valid),
      .hit_addr  (hit_addr),
      .eoe       (eoe),
      .ovf_err   (ovf_err)
   );
endmodule

// File: rtl/strip_hit_pipe_chk.sv
module strip_hit_pipe_chk #(
   parameter int unsigned AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig,
   input logic          busy,
   input logic          hit_valid,
   input logic [AW-1:0] hit_addr,
   input logic          eoe,
   input logic          ovf_err
);
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_valid, eoe}));

   assert_idle_after_eoe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoe |=> (!hit_valid && !eoe));

   assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && $past(hit_valid)) |-> (hit_addr > $past(hit_addr)));

   assert_out_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid || eoe) |-> busy);

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_err) |-> $past(trig && busy));
endmodule

bind strip_hit_pipe strip_hit_pipe_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig      (trig),
   .busy      (rd_busy),
   .hit_valid (hit_valid),
   .hit_addr  (hit_addr),
   .eoe       (eoe),
   .ovf_err   (ovf_err)
);

// File: tb/strip_hit_pipe_tb.sv
module strip_hit_pipe_tb;
   localparam int NCH   = 128;
   localparam int DEPTH = 132;

   typedef struct packed {
      logic         lvl;
      logic [1:0]   hold;
      logic [8:0]   off;
      logic [127:0] pat;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{lvl:1'b1, hold:2'd1, off:9'd132, pat:128'h1},                                   // R3 R4 channel 0
      '{lvl:1'b1, hold:2'd1, off:9'd132, pat:{1'b1, 126'h0, 1'b1}},                     // R4 both ends
      '{lvl:1'b1, hold:2'd1, off:9'd131, pat:128'hF0},                                  // R3 one edge early
      '{lvl:1'b1, hold:2'd1, off:9'd133, pat:128'hF0},                                  // R3 one edge late
      '{lvl:1'b0, hold:2'd1, off:9'd132, pat:128'h0000_00F0_0000_0000_0000_0000_0000_0300}, // R2 fresh edge
      '{lvl:1'b0, hold:2'd2, off:9'd133, pat:128'hFF},                                  // R2 held high
      '{lvl:1'b1, hold:2'd2, off:9'd133, pat:128'hFF},                                  // R1 held high
      '{lvl:1'b1, hold:2'd1, off:9'd132, pat:128'h0},                                   // R5 empty event
      '{lvl:1'b1, hold:2'd1, off:9'd132, pat:{128{1'b1}}}                               // R4 R5 all channels
   };

   logic           clk = 1'b0;
   logic           rst_n;
   logic           sense_level;
   logic [NCH-1:0] comp;
   logic           trig;
   logic           hit_valid;
   logic [6:0]     hit_addr;
   logic           eoe;
   logic           ovf_err;

   int ntests = 0;
   int nfail  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   strip_hit_pipe #(.NCH(NCH), .DEPTH(DEPTH)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sense_level (sense_level),
      .comp        (comp),
      .trig        (trig),
      .hit_valid   (hit_valid),
      .hit_addr    (hit_addr),
      .eoe         (eoe),
      .ovf_err     (ovf_err)
   );

   task automatic check(bit ok, string req, string what, int act, int exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int next_set(logic [127:0] p, int from);
      for (int i = from; i < NCH; i++) if (p[i]) return i;
      return NCH;
   endfunction

   // Expected slice from the rules R1, R2, R3: only the slice offset-DEPTH edges after E.
   function automatic logic [127:0] expect_of(vec_t v);
      int idx = int'(v.off) - DEPTH;
      if (idx < 0 || idx >= int'(v.hold)) return '0;
      if (idx == 0) return v.pat;
      return v.lvl ? v.pat : '0;
   endfunction

   // Trigger sampled at posedge number edge_no; returns at the negedge right after it.
   task automatic fire(int edge_no);
      while (cyc < edge_no - 1) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
   endtask

   // Words due on consecutive cycles from the first negedge after the trigger edge (R4, R5).
   task automatic collect(logic [127:0] exp, string req, bit retrig);
      int k = 0;
      int ch = next_set(exp, 0);
      bit ok = 1'b1;
      int act = 0;
      int want = 0;
      for (int i = 0; i < NCH; i++) if (exp[i]) k++;
      for (int i = 0; i <= k; i++) begin
         if (i < k) begin
            if (!(hit_valid && !eoe && int'(hit_addr) == ch)) begin
               ok = 1'b0; act = hit_valid ? int'(hit_addr) : -1; want = ch;
            end
            ch = next_set(exp, ch + 1);
         end else if (!(eoe && !hit_valid)) begin
            ok = 1'b0; act = hit_valid ? int'(hit_addr) : -1; want = -2;
         end
         if (!retrig || i > 0) trig = 1'b0;
         if (!ok) break;
         @(negedge clk);
      end
      trig = 1'b0;
      check(ok, req, "readout word (-1 none, -2 marker)", act, want);
      if (ok) check(!hit_valid && !eoe, "R8", "idle after marker", int'({hit_valid, eoe}), 0);
   endtask

   task automatic run(logic lvl, int hold, int off, logic [127:0] pat,
                      logic [127:0] exp, string req, bit retrig);
      int e;
      @(negedge clk);
      sense_level = lvl;
      comp = '0;
      repeat (3) @(negedge clk);
      comp = pat;
      e = cyc + 1;
      repeat (hold) @(negedge clk);
      comp = '0;
      fire(e + off);
      collect(exp, req, retrig);
   endtask

   initial begin
      rst_n = 1'b0; sense_level = 1'b1; comp = '0; trig = 1'b0;
      repeat (4) @(negedge clk);
      check(!hit_valid && !eoe && !ovf_err, "R7", "outputs in reset",
            int'({hit_valid, eoe, ovf_err}), 0);
      rst_n = 1'b1;

      for (int n = 0; n < NV; n++) begin
         string req;
         req = (n == 6) ? "R1" : (n == 4 || n == 5) ? "R2" :
               (n == 2 || n == 3) ? "R3" : (n == 7) ? "R5" : "R4";
         run(VEC[n].lvl, int'(VEC[n].hold), int'(VEC[n].off), VEC[n].pat,
             expect_of(VEC[n]), req, 1'b0);
      end

      // R6: second trigger while busy is dropped, flag set and sticky.
      check(!ovf_err, "R6", "flag before overflow", int'(ovf_err), 0);
      run(1'b1, 1, DEPTH, 128'h8421, 128'h8421, "R6", 1'b1);
      check(ovf_err, "R6", "flag after dropped trigger", int'(ovf_err), 1);
      begin
         int extra = 0;
         for (int i = 0; i < DEPTH + 8; i++) begin
            if (hit_valid || eoe) extra++;
            @(negedge clk);
         end
         check(extra == 0, "R6", "output cycles from dropped trigger", extra, 0);
      end
      check(ovf_err, "R6", "flag still set", int'(ovf_err), 1);

      // R7: reset clears the flag; edge mode sees no edge on a bit already high.
      rst_n = 1'b0; sense_level = 1'b0; comp = '1;
      repeat (3) @(negedge clk);
      check(!ovf_err && !hit_valid && !eoe, "R7", "state after second reset",
            int'({hit_valid, eoe, ovf_err}), 0);
      rst_n = 1'b1;
      begin
         int e0 = cyc + 1;
         fire(e0 + 2);
         collect('0, "R7", 1'b0);
         fire(e0 + DEPTH);
         collect('0, "R7", 1'b0);
      end
      comp = '0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         ntests++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end
endmodule